// File: doc/BRIEF.md
# Conditional Trap Evaluator

This block decides whether a conditional trap instruction must raise a program exception. It receives two operands and a five-bit condition field, evaluates the signed and unsigned comparisons of the two operands at the same time, and raises a trap request when at least one comparison selected by the condition field is true. A width select chooses the word form, which compares only the low 32 bits of each operand, or the doubleword form, which compares the full 64 bits.

The result is registered. The trap request and its cause code appear one clock after the instruction-valid strobe. While a trap is requested, the cause output carries a fixed code meaning "program exception, trap". Otherwise the cause output is zero. Steering the processor to an exception vector is left to the surrounding pipeline.

Top module: `trap_eval`

## Requirements
- R1: Condition bit 4 (value 0x10) enables a trap when op_a is less than op_b, both taken as two's-complement signed numbers.
- R2: Condition bit 3 (value 0x08) enables a trap when op_a is greater than op_b as signed numbers.
- R3: Condition bit 2 (value 0x04) enables a trap when op_a equals op_b over the compared width.
- R4: Condition bit 1 (value 0x02) enables a trap when op_a is less than op_b as unsigned numbers.
- R5: Condition bit 0 (value 0x01) enables a trap when op_a is greater than op_b as unsigned numbers.
- R6: The trap is the logical OR of all enabled conditions. Exactly one of signed-less, signed-greater and equal holds for any valid operand pair.
- R7: With dword_sel = 0 (word form) only bits 31:0 of each operand are compared, and bits 63:32 have no effect on trap_req.
- R8: With dword_sel = 1 (doubleword form) all 64 bits of each operand are compared, with bit 63 as the sign.
- R9: trap_req is registered and reflects the instruction presented one cycle earlier. It is 0 after any cycle in which insn_vld was 0, and it is 0 during reset.
- R10: A condition field of 0 never traps. A condition field of 5'b11111 always traps.
- R11: trap_cause equals TRAP_CODE (default 8'h41) in every cycle where trap_req is 1, and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_vld | input | 1 | A trap instruction is presented this cycle |
| dword_sel | input | 1 | 1 selects the 64-bit compare, 0 selects the 32-bit compare |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| cond | input | 5 | Condition enable field |
| trap_req | output | 1 | Registered trap request |
| trap_cause | output | 8 | Registered exception cause code |

## Verification
The assertions assume that insn_vld, dword_sel, cond and both operands are known (not X) whenever reset is released. The bench therefore drives every input to a defined value from time zero, and it also drives operands and cond during idle cycles. The cross-check of the ordering flags assumes only that the compared slice is chosen by dword_sel in the same cycle as insn_vld. The stimulus changes all inputs together at the falling edge. It mixes sign-boundary values, equal-low-word pairs with different upper halves, and random pairs.

// File: rtl/trap_eval_pkg.sv
package trap_eval_pkg;

   // Bit positions inside the condition field; the order sets the trap encoding.
   localparam int COND_W   = 5;
   localparam int C_SLT    = 4;
   localparam int C_SGT    = 3;
   localparam int C_EQ     = 2;
   localparam int C_ULT    = 1;
   localparam int C_UGT    = 0;

   // Field order mirrors the condition bit positions (first field = MSB).
   typedef struct packed {
      logic slt;
      logic sgt;
      logic eq;
      logic ult;
      logic ugt;
   } cmp_flags_t;

endpackage

// File: rtl/trap_cmp_lane.sv
module trap_cmp_lane
   import trap_eval_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output cmp_flags_t   flags
);

   localparam int MSB = W - 1;

   if (W < 2) begin : g_bad_w
      $error("trap_cmp_lane: W must be at least 2");
   end

   logic eq_w;
   logic ult_w;
   logic slt_w;
   logic sign_diff;

   always_comb begin
      eq_w      = (a == b);
      ult_w     = (a < b);
      sign_diff = a[MSB] ^ b[MSB];
      // Different signs: the negative one is smaller; same sign: unsigned order holds.
      slt_w     = sign_diff ? a[MSB] : ult_w;

      flags.eq  = eq_w;
      flags.ult = ult_w;
      flags.ugt = ~ult_w & ~eq_w;
      flags.slt = slt_w;
      flags.sgt = ~slt_w & ~eq_w;
   end

endmodule

// File: rtl/trap_width_sel.sv
module trap_width_sel
   import trap_eval_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int WORD_W    = 32,
   parameter bit HAS_DWORD = 1'b1
) (
   input  logic [XLEN-1:0] op_a,
   input  logic [XLEN-1:0] op_b,
   input  logic            dword_sel,
   output cmp_flags_t      flags
);

   if (WORD_W > XLEN) begin : g_bad_word
      $error("trap_width_sel: WORD_W exceeds XLEN");
   end

   cmp_flags_t word_flags;

   trap_cmp_lane #(.W(WORD_W)) u_word_lane (
      .a     (op_a[WORD_W-1:0]),
      .b     (op_b[WORD_W-1:0]),
      .flags (word_flags)
   );

   if (HAS_DWORD) begin : g_dword
      cmp_flags_t full_flags;

      trap_cmp_lane #(.W(XLEN)) u_full_lane (
         .a     (op_a),
         .b     (op_b),
         .flags (full_flags)
      );

      always_comb flags = dword_sel ? full_flags : word_flags;
   end else begin : g_word_only
      always_comb flags = word_flags;
   end

endmodule

// File: rtl/trap_cond_match.sv
module trap_cond_match
   import trap_eval_pkg::*;
(
   input  cmp_flags_t        flags,
   input  logic [COND_W-1:0] cond,
   output logic              hit
);

   logic [COND_W-1:0] hits;

   for (genvar i = 0; i < COND_W; i++) begin : g_bit
      assign hits[i] = cond[i] & flags[i];
   end

   assign hit = |hits;

endmodule

// File: rtl/trap_eval.sv
module trap_eval
   import trap_eval_pkg::*;
#(
   parameter int              XLEN      = 64,
   parameter int              WORD_W    = 32,
   parameter bit              HAS_DWORD = 1'b1,
   parameter int              CAUSE_W   = 8,
   parameter logic [CAUSE_W-1:0] TRAP_CODE = 8'h41
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               insn_vld,
   input  logic               dword_sel,
   input  logic [XLEN-1:0]    op_a,
   input  logic [XLEN-1:0]    op_b,
   input  logic [COND_W-1:0]  cond,
   output logic               trap_req,
   output logic [CAUSE_W-1:0] trap_cause
);

   localparam logic [COND_W-1:0] COND_ALL = '1;

   if (TRAP_CODE == '0) begin : g_bad_code
      $error("trap_eval: TRAP_CODE must be nonzero");
   end

   cmp_flags_t flags;
   logic       hit;
   logic       fire;

   trap_width_sel #(
      .XLEN      (XLEN),
      .WORD_W    (WORD_W),
      .HAS_DWORD (HAS_DWORD)
   ) u_width_sel (
      .op_a      (op_a),
      .op_b      (op_b),
      .dword_sel (dword_sel),
      .flags     (flags)
   );

   trap_cond_match u_match (
      .flags (flags),
      .cond  (cond),
      .hit   (hit)
   );

   assign fire = insn_vld & hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trap_req   <= 1'b0;
         trap_cause <= '0;
      end else begin
         trap_req   <= fire;
         trap_cause <= fire ? TRAP_CODE : '0;
      end
   end

   // Signed ordering flags from the lanes are mutually exclusive and complete.
   p_order_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      insn_vld |-> ($countones({flags.slt, flags.sgt, flags.eq}) == 1));

   p_order_uexcl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      insn_vld |-> ($countones({flags.ult, flags.ugt, flags.eq}) == 1));

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_vld |=> !trap_req);

   p_zero_never_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_vld && cond == '0) |=> !trap_req);

   p_ones_always_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_vld && cond == COND_ALL) |=> trap_req);

   p_cause_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (trap_cause == TRAP_CODE));

   p_cause_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_req |-> (trap_cause == '0));

endmodule

// File: tb/trap_eval_tb.sv
module trap_eval_tb;

   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] CODE = 8'h41;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_vld = 1'b0;
   logic        dword_sel = 1'b0;
   logic [63:0] op_a = '0;
   logic [63:0] op_b = '0;
   logic [4:0]  cond = '0;
   logic        trap_req;
   logic [7:0]  trap_cause;

   int n_checks = 0;
   int n_fails  = 0;
   bit stim_done = 1'b0;

   typedef struct {
      logic  req;
      string tag;
   } exp_t;

   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   trap_eval u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .insn_vld   (insn_vld),
      .dword_sel  (dword_sel),
      .op_a       (op_a),
      .op_b       (op_b),
      .cond       (cond),
      .trap_req   (trap_req),
      .trap_cause (trap_cause)
   );

   // Reference model written directly from R1..R8.
   function automatic logic model(logic [63:0] a, logic [63:0] b, logic [4:0] c, logic dw);
      logic slt, sgt, eq, ult, ugt;
      if (dw) begin                               // R8
         slt = $signed(a) < $signed(b);
         sgt = $signed(a) > $signed(b);
         eq  = a == b;
         ult = a < b;
         ugt = a > b;
      end else begin                              // R7
         slt = $signed(a[31:0]) < $signed(b[31:0]);
         sgt = $signed(a[31:0]) > $signed(b[31:0]);
         eq  = a[31:0] == b[31:0];
         ult = a[31:0] < b[31:0];
         ugt = a[31:0] > b[31:0];
      end
      return (c[4] & slt) | (c[3] & sgt) | (c[2] & eq) | (c[1] & ult) | (c[0] & ugt);
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(logic [63:0] a, logic [63:0] b, logic [4:0] c, logic dw, string tag);
      exp_t e;
      @(negedge clk);
      insn_vld  = 1'b1;
      op_a      = a;
      op_b      = b;
      cond      = c;
      dword_sel = dw;
      e.req = model(a, b, c, dw);
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle(string tag);
      exp_t e;
      @(negedge clk);
      insn_vld  = 1'b0;
      op_a      = {$urandom, $urandom};
      op_b      = {$urandom, $urandom};
      cond      = 5'b11111;                       // R9: would trap if valid
      dword_sel = $urandom_range(0, 1);
      e.req = 1'b0;
      e.tag = tag;
      sb.push_back(e);
   endtask

   // Monitor: pops one expected item per cycle after the edge that registers it.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, {63'd0, trap_req}, {63'd0, e.req});
            check({e.tag, "/R11"}, {56'd0, trap_cause}, e.req ? {56'd0, CODE} : 64'd0);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset req", {63'd0, trap_req}, 64'd0);
      check("R11 reset cause", {56'd0, trap_cause}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 signed less-than across sign boundary
      drive(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'b10000, 1'b1, "R1 neg<pos dw");
      drive(64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 5'b10000, 1'b1, "R1 pos!<neg dw");
      // R2 signed greater-than
      drive(64'd5, 64'h8000_0000_0000_0000, 5'b01000, 1'b1, "R2 pos>min dw");
      drive(64'd5, 64'd5, 5'b01000, 1'b1, "R2 equal no trap");
      // R3 equality
      drive(64'h1234, 64'h1234, 5'b00100, 1'b1, "R3 eq dw");
      drive(64'h1234, 64'h1235, 5'b00100, 1'b1, "R3 ne dw");
      // R4 unsigned less-than, where signed order disagrees
      drive(64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 5'b00010, 1'b1, "R4 ult dw");
      drive(64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 5'b10000, 1'b1, "R4 signed view differs");
      // R5 unsigned greater-than
      drive(64'h8000_0000_0000_0000, 64'd3, 5'b00001, 1'b1, "R5 ugt dw");
      drive(64'd2, 64'd3, 5'b00001, 1'b1, "R5 not ugt");
      // R6 OR of several enables
      drive(64'd9, 64'd4, 5'b10101, 1'b1, "R6 or ugt");
      drive(64'd4, 64'd9, 5'b01101, 1'b1, "R6 none hit");
      // R7 word form ignores upper half
      drive(64'hAAAA_0000_0000_0007, 64'h5555_0000_0000_0007, 5'b00100, 1'b0, "R7 eq low word");
      drive(64'h0000_0000_FFFF_FFFF, 64'h7FFF_FFFF_0000_0001, 5'b10000, 1'b0, "R7 word sign");
      drive(64'h0000_0000_FFFF_FFFF, 64'h7FFF_FFFF_0000_0001, 5'b00010, 1'b0, "R7 word unsigned");
      // R8 same pattern in doubleword form
      drive(64'hAAAA_0000_0000_0007, 64'h5555_0000_0000_0007, 5'b00100, 1'b1, "R8 upper differs");
      drive(64'h0000_0000_FFFF_FFFF, 64'h7FFF_FFFF_0000_0001, 5'b10000, 1'b1, "R8 full sign");
      // R9 idle cycles
      idle("R9 idle");
      idle("R9 idle");
      // R10 corner fields
      drive(64'd7, 64'd3, 5'b00000, 1'b1, "R10 zero field");
      drive(64'd7, 64'd7, 5'b11111, 1'b0, "R10 ones field");
      drive(64'd0, 64'hFF, 5'b11111, 1'b1, "R10 ones field lt");
      idle("R9 idle after");

      for (int i = 0; i < 300; i++) begin
         logic [63:0] a, b;
         a = {$urandom, $urandom};
         b = ($urandom_range(0, 3) == 0) ? a : {$urandom, $urandom};
         if ($urandom_range(0, 3) == 0) b[31:0] = a[31:0];
         if ($urandom_range(0, 7) == 0) idle("R9 random idle");
         else drive(a, b, 5'($urandom), 1'($urandom), "R6 random");
      end
      idle("R9 drain");
      repeat (3) @(negedge clk);
      stim_done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (stim_done);
         end
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hang expected=finish");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule